// File: doc/BRIEF.md
# Indexed EEPROM Data Reader

This block lets a host read product data kept in a 256-byte serial EEPROM on a two-wire bus. The host writes a byte position into an index register. That write starts a serial random read on its own. The read sends the device address for writing, then the word address, then a repeated start and the device address for reading, and then receives two consecutive bytes. When the fetch finishes, a status byte reports whether the data can be used, and a 16-bit data register returns the indexed byte together with the byte that follows it.

Access is read-only. Host writes to the data register are ignored, and the block never writes to the EEPROM. The serial clock is derived from the system clock by a parameterised divider. The data line is open-drain: the block either pulls it low or releases it, and it samples the resolved line through `sda_i`. If the device does not acknowledge an address byte, the transfer is abandoned with a stop condition and an error flag is raised in place of the valid flag.

Top module: `eeprom_idx_reader`

## Requirements
- R1: After reset the index reads 0, the status reads 0x00, the data register reads 0x0000, SCL is high and SDA is released.
- R2: A host write with select 0 while no fetch is running stores `reg_wdata[7:0]` as the index. The index reads back in the low byte at select 0. The write clears the valid and error flags and starts a fetch, so status (select 1) reads 0x04 (bit 2 = busy) from the next cycle.
- R3: A fetch sends a start condition, the byte {DEV_ADDR,0}, the index, a repeated start and {DEV_ADDR,1}, most significant bit first. It then receives two bytes, answering ACK after the first and NACK after the second, and ends with a stop. Each SCL period is 4*CLK_DIV system clocks.
- R4: When a fetch completes with every address byte acknowledged, status reads 0x01. The data register (select 2) reads the byte at the index in bits 7:0 and the byte at index+1 in bits 15:8.
- R5: For index 255 the high data byte is the EEPROM byte at position 0.
- R6: If any address byte is not acknowledged, the block issues a stop, releases the bus, and status reads 0x02 (bit 1 = error, bit 0 clear).
- R7: A host write with select 2 changes neither the status, the data register nor the index.
- R8: An index write while a fetch is running is ignored. The index keeps its value, and the result belongs to the original index.
- R9: The data register reads 0x0000 whenever status bit 0 is clear.
- R10: SDA is only ever pulled low or released. While no fetch is running, SCL is high and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Host register write strobe |
| reg_sel | input | 2 | Register select: 0 index, 1 status, 2 data |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| scl_o | output | 1 | Serial clock |
| sda_low_o | output | 1 | 1 pulls the serial data line low, 0 releases it |
| sda_i | input | 1 | Resolved level of the serial data line |

## Verification
A wrong segment or bit counter inside the serial sequencer shows up at once as a wrong byte received by the EEPROM model. It can also show up as an acknowledge the model never gives, and the status then ends at 0x02 instead of 0x01, one transfer later. A flag that is wrongly held or cleared in the register stage appears in the status read on the very next cycle after an index write. A corrupted data latch appears in the first data read after busy drops. A stuck serial pin is visible on any idle read of the bus.

// File: rtl/eeprom_idx_pkg.sv
package eeprom_idx_pkg;
  // transfer segments in bus order; the sequencer steps through them in turn
  typedef enum logic [2:0] {
    SG_START, SG_DEVW, SG_WADDR, SG_RESTART, SG_DEVR, SG_RD0, SG_RD1, SG_STOP
  } seg_e;

  localparam logic [1:0] SEL_INDEX  = 2'd0;
  localparam logic [1:0] SEL_STATUS = 2'd1;
  localparam logic [1:0] SEL_DATA   = 2'd2;
endpackage

// File: rtl/eeprom_idx_tick.sv
module eeprom_idx_tick #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  generate
    if (DIV > 1) begin : g_spacing
      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R3
    end
  endgenerate
endmodule

// File: rtl/eeprom_idx_seq.sv
module eeprom_idx_seq
  import eeprom_idx_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] index,
  input  logic       tick,
  input  logic       sda_i,
  output logic       busy,
  output logic       done,
  output logic       fail,
  output logic [7:0] byte_lo,
  output logic [7:0] byte_hi,
  output logic       scl_o,
  output logic       sda_low_o
);
  seg_e       seg;
  logic [1:0] q;      // quarter of the current bit
  logic [3:0] bitn;   // 0..7 data bits, 8 = acknowledge slot
  logic [7:0] sh;
  logic [7:0] idx_q;
  logic       nack_q;
  logic       is_start, is_tx, is_rx, scl_nx, sda_nx;

  always_comb begin
    is_start = (seg == SG_START) || (seg == SG_RESTART);
    is_tx    = (seg == SG_DEVW) || (seg == SG_WADDR) || (seg == SG_DEVR);
    is_rx    = (seg == SG_RD0) || (seg == SG_RD1);
    scl_nx   = 1'b1;
    sda_nx   = 1'b0;
    if (is_start) begin
      scl_nx = (q == 2'd0) ? scl_o : (q != 2'd3);
      sda_nx = q[1];                       // fall while SCL is high
    end else if (seg == SG_STOP) begin
      scl_nx = (q != 2'd0);
      sda_nx = !q[1];                      // rise while SCL is high
    end else begin
      scl_nx = (q == 2'd1) || (q == 2'd2);
      if (is_tx && !bitn[3])     sda_nx = !sh[7];
      else if (is_rx && bitn[3]) sda_nx = (seg == SG_RD0);  // ACK first, NACK last
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; fail <= 1'b0;
      seg <= SG_START; q <= '0; bitn <= '0; sh <= '0; idx_q <= '0; nack_q <= 1'b0;
      byte_lo <= '0; byte_hi <= '0; scl_o <= 1'b1; sda_low_o <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; fail <= 1'b0; idx_q <= index;
          seg <= SG_START; q <= '0; bitn <= '0;
        end
      end else if (tick) begin
        scl_o     <= scl_nx;
        sda_low_o <= sda_nx;
        q         <= q + 2'd1;
        if (q == 2'd2) begin
          if (is_rx && !bitn[3]) sh <= {sh[6:0], sda_i};
          if (is_tx && bitn[3])  nack_q <= sda_i;
        end
        if (q == 2'd3) begin
          if (is_start) begin
            sh   <= {DEV_ADDR, (seg == SG_RESTART)};
            bitn <= '0;
            seg  <= seg_e'(seg + 3'd1);
          end else if (seg == SG_STOP) begin
            busy <= 1'b0; done <= 1'b1; seg <= SG_START;
          end else if (!bitn[3]) begin
            bitn <= bitn + 4'd1;
            if (is_tx) sh <= {sh[6:0], 1'b0};
          end else begin
            bitn <= '0;
            if (is_tx && nack_q) begin
              fail <= 1'b1; seg <= SG_STOP;
            end else begin
              if (seg == SG_DEVW) sh <= idx_q;
              if (seg == SG_RD0)  byte_lo <= sh;
              if (seg == SG_RD1)  byte_hi <= sh;
              seg <= seg_e'(seg + 3'd1);
            end
          end
        end
      end
    end
  end

  AST_IDLE_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl_o && !sda_low_o)); // R10
  AST_PINS_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(scl_o) && $stable(sda_low_o))); // R3
endmodule

// File: rtl/eeprom_idx_reader.sv
module eeprom_idx_reader
  import eeprom_idx_pkg::*;
#(
  parameter int         CLK_DIV  = 8,
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        scl_o,
  output logic        sda_low_o,
  input  logic        sda_i
);
  logic       tick, busy, done, fail, start;
  logic [7:0] byte_lo, byte_hi, idx_q, status;
  logic       valid_q, err_q;

  assign start = reg_wr && (reg_sel == SEL_INDEX) && !busy;

  eeprom_idx_tick #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  eeprom_idx_seq #(.DEV_ADDR(DEV_ADDR)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .index(reg_wdata[7:0]),
    .tick(tick), .sda_i(sda_i), .busy(busy), .done(done), .fail(fail),
    .byte_lo(byte_lo), .byte_hi(byte_hi), .scl_o(scl_o), .sda_low_o(sda_low_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0; valid_q <= 1'b0; err_q <= 1'b0;
    end else if (start) begin
      idx_q <= reg_wdata[7:0]; valid_q <= 1'b0; err_q <= 1'b0;
    end else if (done) begin
      valid_q <= !fail; err_q <= fail;
    end
  end

  assign status = {5'd0, busy, err_q, valid_q};

  always_comb begin
    case (reg_sel)
      SEL_INDEX:  reg_rdata = {8'd0, idx_q};
      SEL_STATUS: reg_rdata = {8'd0, status};
      SEL_DATA:   reg_rdata = valid_q ? {byte_hi, byte_lo} : 16'd0;
      default:    reg_rdata = 16'd0;
    endcase
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_q && err_q)); // R6
  AST_BUSY_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!valid_q && !err_q)); // R2
  AST_DATA_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_DATA && !busy && !done)
      |=> ($stable(idx_q) && $stable(valid_q) && $stable(err_q))); // R7
  AST_INDEX_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_INDEX && busy) |=> $stable(idx_q)); // R8
endmodule

// File: tb/tb_eeprom_idx_reader.sv
module tb_eeprom_idx_reader;
  localparam logic [6:0] DEV = 7'h50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        scl_o, sda_low;
  logic        m_low = 1'b0;
  logic        sda_line;
  int          n_chk = 0;
  int          n_bad = 0;
  logic        finished = 1'b0;

  assign sda_line = !(sda_low || m_low);

  always #2 clk = ~clk;  // 4-unit period, 250 MHz at 1 ns units

  eeprom_idx_reader dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_o(scl_o), .sda_low_o(sda_low), .sda_i(sda_line)
  );

  // ---------------- two-wire EEPROM model ----------------
  logic [7:0] mem [256];
  logic [7:0] rx_log [8];
  int         rx_n = 0;
  logic       m_act = 0, m_skip = 0, m_rd = 0, m_first = 0, m_mack = 0, m_ack = 0, m_mute = 0;
  int         m_bit = 0;
  logic [7:0] m_sh = 0, m_tx = 0, ptr = 0;

  always @(negedge sda_line) if (scl_o) begin
    m_act = 1; m_skip = 1; m_rd = 0; m_first = 1; m_bit = 0; m_low = 0;
  end
  always @(posedge sda_line) if (scl_o) begin
    m_act = 0; m_low = 0;
  end
  always @(posedge scl_o) if (m_act) begin
    if (!m_rd && m_bit < 8) m_sh = {m_sh[6:0], sda_line};
    if (m_rd && m_bit == 8) m_mack = sda_line;
  end
  always @(negedge scl_o) if (m_act) begin
    if (m_skip) m_skip = 0;
    else if (m_bit < 7) begin
      m_bit = m_bit + 1;
      if (m_rd) m_low = !m_tx[7 - m_bit];
    end else if (m_bit == 7) begin
      m_bit = 8;
      if (m_rd) m_low = 0;
      else begin
        if (rx_n < 8) rx_log[rx_n] = m_sh;
        rx_n = rx_n + 1;
        if (m_first) m_ack = (m_sh[7:1] == DEV) && !m_mute;
        else begin ptr = m_sh; m_ack = 1; end
        m_low = m_ack;
      end
    end else begin
      m_bit = 0; m_low = 0;
      if (m_rd) begin
        if (!m_mack) begin ptr = ptr + 8'd1; m_tx = mem[ptr]; m_low = !m_tx[7]; end
        else m_act = 0;
      end else if (!m_ack) m_act = 0;
      else if (m_first) begin
        m_first = 0;
        if (m_sh[0]) begin m_rd = 1; m_tx = mem[ptr]; m_low = !m_tx[7]; end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] v);
    @(negedge clk); reg_sel = s; #1; v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 5000; i++) begin
      rd(2'd1, v);
      if (!v[2]) break;
    end
    chk("R3 fetch finishes", {15'd0, v[2]}, 16'd0);
  endtask

  task automatic bus_idle(input string req);
    chk(req, {14'd0, scl_o, sda_line}, 16'h0003);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [15:0] v;
    rd(2'd0, v); chk("R1 index after reset", v, 16'h0000);
    rd(2'd1, v); chk("R1 status after reset", v, 16'h0000);
    rd(2'd2, v); chk("R1/R9 data after reset", v, 16'h0000);
    bus_idle("R1/R10 bus idle after reset");
  endtask

  task automatic t_fetch(input logic [7:0] idx, input string req);
    logic [15:0] v;
    logic [7:0]  nx;
    nx = idx + 8'd1;
    rx_n = 0;
    wr(2'd0, {8'hA5, idx});
    rd(2'd1, v); chk("R2 status busy after index write", v, 16'h0004);
    rd(2'd0, v); chk("R2 index readback", v, {8'd0, idx});
    rd(2'd2, v); chk("R9 data hidden while busy", v, 16'h0000);
    wait_idle();
    rd(2'd1, v); chk("R4 status valid", v, 16'h0001);
    rd(2'd2, v); chk(req, v, {mem[nx], mem[idx]});
    chk("R3 byte count on bus", 16'(rx_n), 16'd3);
    chk("R3 device write byte", {8'd0, rx_log[0]}, {8'd0, DEV, 1'b0});
    chk("R3 word address byte", {8'd0, rx_log[1]}, {8'd0, idx});
    chk("R3 device read byte", {8'd0, rx_log[2]}, {8'd0, DEV, 1'b1});
    bus_idle("R10 bus idle after fetch");
  endtask

  task automatic t_data_write();
    logic [15:0] v;
    wr(2'd2, 16'hBEEF);
    rd(2'd1, v); chk("R7 status after data write", v, 16'h0001);
    rd(2'd2, v); chk("R7 data after data write", v, {mem[8'h11], mem[8'h10]});
    rd(2'd0, v); chk("R7 index after data write", v, 16'h0010);
  endtask

  task automatic t_nack();
    logic [15:0] v;
    m_mute = 1; rx_n = 0;
    wr(2'd0, 16'h0042);
    wait_idle();
    rd(2'd1, v); chk("R6 status error", v, 16'h0002);
    rd(2'd2, v); chk("R6/R9 data hidden on error", v, 16'h0000);
    chk("R6 transfer abandoned after address", 16'(rx_n), 16'd1);
    bus_idle("R6 bus released after error");
    m_mute = 0;
  endtask

  task automatic t_busy_write();
    logic [15:0] v;
    wr(2'd0, 16'h0020);
    wr(2'd0, 16'h0033);
    rd(2'd0, v); chk("R8 index kept during fetch", v, 16'h0020);
    wait_idle();
    rd(2'd1, v); chk("R8 status valid", v, 16'h0001);
    rd(2'd2, v); chk("R8 data of original index", v, {mem[8'h21], mem[8'h20]});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 255);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fetch(8'h10, "R4 data at index 0x10");
    t_data_write();
    t_fetch(8'h00, "R4 data at index 0x00");
    t_fetch(8'hFF, "R5 wrap at index 0xFF");
    t_nack();
    t_fetch(8'h7C, "R4 data after error recovery");
    t_busy_write();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule